// File: doc/BRIEF.md
# Strap-Selected Configuration Loader

This block fills the configuration chain of a clock-generation subsystem once per reset. When reset is released it looks at a mode strap and picks one of three sources: a host that clocks bits in over a slow serial clock and data pin, a neighbouring serial-memory reader that hands over one bit at a time with a strobe, or a bank of eight built-in presets chosen by three select pins. The block runs on a fast system clock. It oversamples the slow serial clock through a synchronizer and detects its rising edges.

Once the chain is full, the block splits it into named fields: two clock-routing flags, a PLL bypass flag, a 6-bit feedback divider, a 7-bit reference divider, a 2-bit output range code and, in the 19-bit build only, a deskew-disable flag. It also checks the divider ratio against the minimum phase-detector input frequency. The block then raises a one-cycle done pulse. After that it holds a valid or bad verdict and the decoded fields until the next reset.

Top module: `cfg_loader`

## Requirements
- R1: While `rst` is high, every field output, `cfg_done`, `cfg_valid` and `cfg_bad` are 0.
- R2: The source is latched at the last clock edge with `rst` high. `strap_valid`=0 selects the serial-memory source. `strap_valid`=1 with `strap_level`=1 selects the host source. `strap_valid`=1 with `strap_level`=0 selects the preset source. Changes to the strap after reset release have no effect.
- R3: In host mode, each rising edge of `ser_clk` shifts in one bit taken from `ser_data`. The edge is seen after a two-flop synchronizer. The first bit received ends at chain index 0. The chain is full after 19 edges (18 in the base build), and later edges do not change anything until the next reset.
- R4: In serial-memory mode, each clock cycle with `ee_bit_vld`=1 shifts in `ee_bit`, with the same bit ordering as R3. `ser_clk` activity is ignored in this mode, and `ee_bit_vld` is ignored in host mode.
- R5: In preset mode, the preset index is {`rom_msb`, `ser_clk`, `ser_data`}, with `rom_msb` as the MSB, sampled with the strap. The selected preset loads at the first edge after reset release, and `cfg_done` is high in the cycle after that edge.
- R6: Chain layout: index 0 is `cfg_cm`, index 1 is `cfg_cs`, index 2 is `cfg_test`, indices 8..3 are `cfg_m`, indices 15..9 are `cfg_n`, indices 17..16 are `cfg_r`, and index 18 is `cfg_ddsk`.
- R7: In the default preset bank, preset 7 has `cfg_test`=1, presets 0 to 2 have `cfg_cm`=1 and `cfg_cs`=1, and every preset passes the ratio check.
- R8: `cfg_valid`=1 when (N+1)·2^R ≤ 128; otherwise `cfg_bad`=1. The two are never high together.
- R9: `cfg_done` is high for exactly one cycle per reset. The verdict and the fields then hold until reset.
- R10: In the 18-bit build, `cfg_ddsk` is always 0 and the chain completes after 18 shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_valid | input | 1 | Strap is driven (0 = floating level) |
| strap_level | input | 1 | Strap level when driven |
| rom_msb | input | 1 | Preset index MSB |
| ser_clk | input | 1 | Slow serial clock / preset index bit 1 |
| ser_data | input | 1 | Serial data / preset index bit 0 |
| ee_bit_vld | input | 1 | Bit strobe from serial-memory reader |
| ee_bit | input | 1 | Bit from serial-memory reader |
| cfg_cm | output | 1 | Clock-mode flag |
| cfg_cs | output | 1 | Input clock type select |
| cfg_test | output | 1 | PLL bypass flag |
| cfg_m | output | 6 | Feedback divider |
| cfg_n | output | 7 | Reference divider |
| cfg_r | output | 2 | Output range code |
| cfg_ddsk | output | 1 | Deskew disable |
| cfg_done | output | 1 | One-cycle load-complete pulse |
| cfg_valid | output | 1 | Loaded, ratio within limit |
| cfg_bad | output | 1 | Loaded, ratio over limit |

## Verification
The bench builds two copies side by side and drives both with the same inputs. The first is a 19-bit build with a bench-supplied preset bank in which every entry is distinct, so a wrong preset index cannot go unnoticed. The second is an 18-bit build with the default bank. Because the host stream is shared, the 18-bit copy completes one edge before the 19-bit copy, and its fields must then survive the extra edge; this checks both the length boundary and the rule that later edges are ignored. The default-bank copy brings the preset properties of R7 within reach.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int CHAIN_MAX = 19;
  localparam int M_W = 6;
  localparam int N_W = 7;
  localparam int R_W = 2;
  localparam int NUM_PRESETS = 8;

  typedef enum logic [1:0] {SRC_EEPROM = 2'd0, SRC_HOST = 2'd1, SRC_ROM = 2'd2} src_e;
  typedef enum logic [1:0] {ST_FILL = 2'd0, ST_DECODE = 2'd1, ST_HOLD = 2'd2} st_e;

  typedef struct packed {
    logic           ddsk;
    logic [R_W-1:0] r;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
    logic           test;
    logic           cs;
    logic           cm;
  } cfg_t;

  function automatic logic [CHAIN_MAX-1:0] pack_cfg(input logic ddsk, input logic [R_W-1:0] r,
      input logic [N_W-1:0] n, input logic [M_W-1:0] m, input logic test, input logic cs,
      input logic cm);
    return {ddsk, r, n, m, test, cs, cm};
  endfunction

  localparam logic [NUM_PRESETS-1:0][CHAIN_MAX-1:0] DEFAULT_PRESETS = {
    pack_cfg(1'b0, 2'd0, 7'd0, 6'd0, 1'b1, 1'b0, 1'b0),  // 7: PLL bypass
    pack_cfg(1'b0, 2'd3, 7'd3, 6'd1, 1'b0, 1'b0, 1'b0),  // 6
    pack_cfg(1'b0, 2'd0, 7'd2, 6'd5, 1'b0, 1'b0, 1'b0),  // 5
    pack_cfg(1'b0, 2'd1, 7'd5, 6'd2, 1'b0, 1'b0, 1'b0),  // 4: 2x
    pack_cfg(1'b0, 2'd1, 7'd0, 6'd0, 1'b0, 1'b0, 1'b0),  // 3: zero phase
    pack_cfg(1'b0, 2'd0, 7'd1, 6'd3, 1'b0, 1'b1, 1'b1),  // 2: follower
    pack_cfg(1'b0, 2'd2, 7'd3, 6'd1, 1'b0, 1'b1, 1'b1),  // 1: follower
    pack_cfg(1'b0, 2'd1, 7'd0, 6'd0, 1'b0, 1'b1, 1'b1)   // 0: follower
  };
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    pipe[0] <= d;
    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_rom.sv
module cfg_rom
  import cfg_loader_pkg::*;
#(
  parameter int CHAIN_LEN = 19,
  parameter logic [NUM_PRESETS-1:0][CHAIN_MAX-1:0] PRESETS = DEFAULT_PRESETS,
  localparam int SEL_W = $clog2(NUM_PRESETS)
) (
  input  logic [SEL_W-1:0]     sel,
  output logic [CHAIN_LEN-1:0] word
);
  logic [CHAIN_MAX-1:0] entry;

  always_comb begin
    entry = PRESETS[sel];
    word  = entry[CHAIN_LEN-1:0];
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_loader_pkg::*;
#(
  parameter int CHAIN_LEN   = 19,
  parameter bit HAS_DDSK    = 1'b1,
  parameter int RATIO_LIMIT = 128,
  localparam int PROD_W = N_W + 1 + (1 << R_W)
) (
  input  logic [CHAIN_LEN-1:0] chain,
  output cfg_t                 fields,
  output logic                 ratio_ok
);
  logic [PROD_W-1:0] prod;

  always_comb begin
    fields.cm   = chain[0];
    fields.cs   = chain[1];
    fields.test = chain[2];
    fields.m    = chain[3 +: M_W];
    fields.n    = chain[3 + M_W +: N_W];
    fields.r    = chain[3 + M_W + N_W +: R_W];
    prod        = (PROD_W'(fields.n) + PROD_W'(1)) << fields.r;
    ratio_ok    = (prod <= PROD_W'(RATIO_LIMIT));
  end

  generate
    if (HAS_DDSK) begin : g_ddsk
      assign fields.ddsk = chain[CHAIN_LEN-1];
    end else begin : g_no_ddsk
      assign fields.ddsk = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter bit HAS_DDSK    = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int RATIO_LIMIT = 128,
  parameter logic [NUM_PRESETS-1:0][CHAIN_MAX-1:0] ROM_PRESETS = DEFAULT_PRESETS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           strap_valid,
  input  logic           strap_level,
  input  logic           rom_msb,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ee_bit_vld,
  input  logic           ee_bit,
  output logic           cfg_cm,
  output logic           cfg_cs,
  output logic           cfg_test,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [R_W-1:0] cfg_r,
  output logic           cfg_ddsk,
  output logic           cfg_done,
  output logic           cfg_valid,
  output logic           cfg_bad
);
  localparam int CHAIN_LEN = HAS_DDSK ? CHAIN_MAX : CHAIN_MAX - 1;
  localparam int CNT_W     = $clog2(CHAIN_LEN + 1);
  localparam int SEL_W     = $clog2(NUM_PRESETS);

  logic                 sclk_s, sdat_s, sclk_d, sclk_rise;
  logic                 shift_en, shift_bit;
  src_e                 src;
  st_e                  state;
  logic [SEL_W-1:0]     rom_sel;
  logic [CNT_W-1:0]     cnt;
  logic [CHAIN_LEN-1:0] chain, rom_word;
  cfg_t                 dec;
  logic                 dec_ok;

  cfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .d({ser_clk, ser_data}), .q({sclk_s, sdat_s})
  );

  always_ff @(posedge clk) sclk_d <= sclk_s;
  assign sclk_rise = sclk_s & ~sclk_d;

  cfg_rom #(.CHAIN_LEN(CHAIN_LEN), .PRESETS(ROM_PRESETS)) u_rom (
    .sel(rom_sel), .word(rom_word)
  );

  cfg_decode #(.CHAIN_LEN(CHAIN_LEN), .HAS_DDSK(HAS_DDSK), .RATIO_LIMIT(RATIO_LIMIT)) u_dec (
    .chain(chain), .fields(dec), .ratio_ok(dec_ok)
  );

  always_comb begin
    shift_en  = 1'b0;
    shift_bit = 1'b0;
    case (src)
      SRC_HOST:   begin shift_en = sclk_rise;  shift_bit = sdat_s; end
      SRC_EEPROM: begin shift_en = ee_bit_vld; shift_bit = ee_bit; end
      default:    begin shift_en = 1'b0;       shift_bit = 1'b0;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src       <= !strap_valid ? SRC_EEPROM : (strap_level ? SRC_HOST : SRC_ROM);
      rom_sel   <= {rom_msb, sclk_s, sdat_s};
      state     <= ST_FILL;
      cnt       <= '0;
      chain     <= '0;
      cfg_cm    <= 1'b0;
      cfg_cs    <= 1'b0;
      cfg_test  <= 1'b0;
      cfg_m     <= '0;
      cfg_n     <= '0;
      cfg_r     <= '0;
      cfg_ddsk  <= 1'b0;
      cfg_done  <= 1'b0;
      cfg_valid <= 1'b0;
      cfg_bad   <= 1'b0;
    end else begin
      case (state)
        ST_FILL: begin
          if (src == SRC_ROM) begin
            chain <= rom_word;
            state <= ST_DECODE;
          end else if (shift_en) begin
            chain <= {shift_bit, chain[CHAIN_LEN-1:1]};
            cnt   <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(CHAIN_LEN - 1)) state <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          cfg_cm    <= dec.cm;
          cfg_cs    <= dec.cs;
          cfg_test  <= dec.test;
          cfg_m     <= dec.m;
          cfg_n     <= dec.n;
          cfg_r     <= dec.r;
          cfg_ddsk  <= dec.ddsk;
          cfg_done  <= 1'b1;
          cfg_valid <= dec_ok;
          cfg_bad   <= !dec_ok;
          state     <= ST_HOLD;
        end
        default: begin
          cfg_done <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int RATIO_LIMIT = 128
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_cm,
  input logic       cfg_cs,
  input logic       cfg_test,
  input logic [5:0] cfg_m,
  input logic [6:0] cfg_n,
  input logic [1:0] cfg_r,
  input logic       cfg_ddsk,
  input logic       cfg_done,
  input logic       cfg_valid,
  input logic       cfg_bad
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> !cfg_done); // R9

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cfg_valid && cfg_bad)); // R8

  AST_DONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> (cfg_valid || cfg_bad)); // R9

  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid || cfg_bad) |=> ($stable(cfg_valid) && $stable(cfg_bad))); // R9

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid || cfg_bad) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_r) &&
      $stable(cfg_cm) && $stable(cfg_cs) && $stable(cfg_test) && $stable(cfg_ddsk))); // R9

  AST_RATIO_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (((11'(cfg_n) + 11'd1) << cfg_r) <= 11'(RATIO_LIMIT))); // R8
endmodule

bind cfg_loader cfg_loader_chk #(.RATIO_LIMIT(RATIO_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .cfg_cm(cfg_cm), .cfg_cs(cfg_cs), .cfg_test(cfg_test),
  .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_r(cfg_r), .cfg_ddsk(cfg_ddsk),
  .cfg_done(cfg_done), .cfg_valid(cfg_valid), .cfg_bad(cfg_bad)
);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
  function automatic logic [18:0] mk(input logic dd, input logic [1:0] r, input logic [6:0] n,
      input logic [5:0] m, input logic t, input logic cs, input logic cm);
    return {dd, r, n, m, t, cs, cm};
  endfunction

  function automatic logic [7:0][18:0] build_rom();
    logic [7:0][18:0] tbl;
    for (int i = 0; i < 8; i++)
      tbl[i] = mk(i[0], 2'd0, 7'(i + 1), 6'(i + 10), 1'b0, i[1], i[2]);
    return tbl;
  endfunction

  localparam logic [7:0][18:0] TB_ROM = build_rom();
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    mk(1'b0, 2'd1, 7'd5,   6'd2,  1'b0, 1'b0, 1'b0),
    mk(1'b1, 2'd1, 7'd63,  6'd0,  1'b0, 1'b1, 1'b0),
    mk(1'b0, 2'd3, 7'd31,  6'd63, 1'b1, 1'b0, 1'b1),
    mk(1'b1, 2'd0, 7'd127, 6'd21, 1'b0, 1'b1, 1'b1),
    mk(1'b0, 2'd2, 7'd127, 6'd42, 1'b1, 1'b1, 1'b0),
    mk(1'b1, 2'd3, 7'd16,  6'd7,  1'b0, 1'b0, 1'b1)
  };
  localparam bit VEC_OK [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_valid = 1'b1, strap_level = 1'b0, rom_msb = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ee_bit_vld = 1'b0, ee_bit = 1'b0;
  logic a_cm, a_cs, a_test, a_ddsk, a_done, a_valid, a_bad;
  logic [5:0] a_m; logic [6:0] a_n; logic [1:0] a_r;
  logic b_cm, b_cs, b_test, b_ddsk, b_done, b_valid, b_bad;
  logic [5:0] b_m; logic [6:0] b_n; logic [1:0] b_r;
  int errors = 0, checks = 0, dc_a = 0, dc_b = 0;

  always #4 clk = ~clk;

  cfg_loader #(.HAS_DDSK(1'b1), .ROM_PRESETS(TB_ROM)) u_dut (
    .clk(clk), .rst(rst), .strap_valid(strap_valid), .strap_level(strap_level),
    .rom_msb(rom_msb), .ser_clk(ser_clk), .ser_data(ser_data), .ee_bit_vld(ee_bit_vld),
    .ee_bit(ee_bit), .cfg_cm(a_cm), .cfg_cs(a_cs), .cfg_test(a_test), .cfg_m(a_m),
    .cfg_n(a_n), .cfg_r(a_r), .cfg_ddsk(a_ddsk), .cfg_done(a_done), .cfg_valid(a_valid),
    .cfg_bad(a_bad));

  cfg_loader #(.HAS_DDSK(1'b0)) u_dut18 (
    .clk(clk), .rst(rst), .strap_valid(strap_valid), .strap_level(strap_level),
    .rom_msb(rom_msb), .ser_clk(ser_clk), .ser_data(ser_data), .ee_bit_vld(ee_bit_vld),
    .ee_bit(ee_bit), .cfg_cm(b_cm), .cfg_cs(b_cs), .cfg_test(b_test), .cfg_m(b_m),
    .cfg_n(b_n), .cfg_r(b_r), .cfg_ddsk(b_ddsk), .cfg_done(b_done), .cfg_valid(b_valid),
    .cfg_bad(b_bad));

  always @(posedge clk) begin
    if (rst) begin dc_a <= 0; dc_b <= 0; end
    else begin
      if (a_done) dc_a <= dc_a + 1;
      if (b_done) dc_b <= dc_b + 1;
    end
  end

  wire [18:0] a_word = {a_ddsk, a_r, a_n, a_m, a_test, a_cs, a_cm};
  wire [18:0] b_word = {b_ddsk, b_r, b_n, b_m, b_test, b_cs, b_cm};
  wire [2:0]  a_flags = {a_done, a_valid, a_bad};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sv, input logic sl, input logic [2:0] sel);
    @(negedge clk);
    rst = 1'b1; strap_valid = sv; strap_level = sl;
    rom_msb = sel[2]; ser_clk = sel[1]; ser_data = sel[0]; ee_bit_vld = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_host(input logic [18:0] w, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      @(negedge clk); ser_data = w[i]; ee_bit_vld = 1'b1; ee_bit = ~w[i];
      @(negedge clk); ee_bit_vld = 1'b0;
      repeat (2) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    strap_valid = 1'b1; strap_level = 1'b1;
    repeat (4) @(negedge clk);
    chk(a_word == 19'd0 && a_flags == 3'd0, "R1 reset fields/flags", {10'd0, a_flags, a_word[18:0]}, 0);

    // R3 R6 R8 R10: host vectors
    for (int v = 0; v < NV; v++) begin
      logic [18:0] w;
      w = VEC[v];
      do_reset(1'b1, 1'b1, 3'd0);
      send_host(w, 0, 17);
      repeat (8) @(negedge clk);
      chk(dc_a == 0, "R3 no completion before last edge", dc_a, 0);
      chk(dc_b == 1 && b_word == {1'b0, w[17:0]}, "R10 18-bit build fields", b_word, {1'b0, w[17:0]});
      send_host(w, 18, 18);
      send_host(~w, 0, 2);
      repeat (8) @(negedge clk);
      chk(a_word == w, "R6 R3 host fields", a_word, w);
      chk(a_valid == VEC_OK[v] && a_bad == !VEC_OK[v], "R8 ratio verdict", {a_valid, a_bad}, {VEC_OK[v], !VEC_OK[v]});
      chk(dc_a == 1, "R9 one done pulse", dc_a, 1);
      chk(b_word == {1'b0, w[17:0]} && b_valid == VEC_OK[v], "R3 R10 later edges ignored", b_word, {1'b0, w[17:0]});
    end

    // R4: serial-memory source, ser_clk toggles ignored
    begin
      logic [18:0] w;
      w = VEC[3];
      do_reset(1'b0, 1'b1, 3'd0);
      for (int i = 0; i < 19; i++) begin
        @(negedge clk); ee_bit = w[i]; ee_bit_vld = 1'b1;
        @(negedge clk); ee_bit_vld = 1'b0; ser_clk = 1'b1; ser_data = ~w[i];
        repeat (4) @(negedge clk); ser_clk = 1'b0;
        repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(a_word == w && dc_a == 1, "R4 serial-memory fields", a_word, w);
      chk(a_valid == 1'b1, "R4 R8 verdict", a_valid, 1);
    end

    // R5 R11-timing R2 R7: presets
    for (int s = 0; s < 8; s++) begin
      do_reset(1'b1, 1'b0, 3'(s));
      strap_level = 1'b1; strap_valid = 1'b0;
      @(negedge clk);
      chk(a_done == 1'b0, "R5 no done after first edge", a_done, 0);
      @(negedge clk);
      chk(a_done == 1'b1, "R5 done in second cycle", a_done, 1);
      chk(a_word == TB_ROM[s], "R5 R2 preset selected", a_word, TB_ROM[s]);
      chk(b_valid == 1'b1, "R7 default preset ratio ok", b_valid, 1);
      if (s == 7) chk(b_test == 1'b1, "R7 preset 7 bypass", b_test, 1);
      if (s < 3) chk(b_cm && b_cs, "R7 follower presets", {b_cm, b_cs}, 3);
      send_host(19'h7FFFF, 0, 1);
      chk(a_word == TB_ROM[s] && dc_a == 1, "R9 preset held", a_word, TB_ROM[s]);
    end

    // R2: reset mid-shift re-samples strap
    do_reset(1'b1, 1'b1, 3'd0);
    send_host(VEC[0], 0, 5);
    do_reset(1'b1, 1'b0, 3'd6);
    repeat (4) @(negedge clk);
    chk(a_word == TB_ROM[6] && dc_a == 1, "R2 re-sampled after reset", a_word, TB_ROM[6]);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule